// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes a PLL's multiplier safely. Software or a higher-level controller supplies a new multiplier word and raises a start request. The sequencer then performs a fixed series of writes through three register write ports: control, multiplier and divider. First it drives the PLL into power-down with its output gated and its bypass paths cleared. While the PLL is still powered down, it loads the multiplier word and a divider word that sets both the pre-divide and post-divide ratios to one.

Next the sequencer releases power-down and polls the PLL's lock flag. It waits a fixed interval before each look and makes only a limited number of looks. When the PLL locks, the sequencer enables the clock output and pulses done. When it never locks, the sequencer pulses error and leaves the output gated.

The control write keeps every control bit other than the five it manages. To do this, the block takes a copy of the current control register value at the moment it accepts the start. The encoding of the multiplier word and the analog behaviour of the PLL are outside the scope of this block.

Top module: `pll_reprog_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the sequencer is idle. busy, done, error and all three write strobes are low. A reset in the middle of a sequence also returns it to idle.
- R2: One cycle after a start is accepted, the sequencer issues the first control write. In this word, bit 0 (power-down) is set and bits 1 to 4 are cleared: bypass (bit 1), direct-input (bit 2), direct-output (bit 3) and clock-enable (bit 4). All other bits equal the control value sampled with the start.
- R3: In the two cycles after the first control write, the sequencer writes the multiplier word and then the divider word 0x00302062. Both writes happen while the last control word written has power-down set.
- R4: In the next cycle, a second control write clears bit 0 and otherwise repeats the R2 word.
- R5: After power-up, the lock input is sampled once at the end of each wait of WAIT_CYC cycles. There are at most MAX_TRIES (4) samples. A sample k that shows lock ends the wait at cycle 4 + k*WAIT_CYC after acceptance.
- R6: On lock, the next cycle carries a control write of the R4 word with bit 4 set, together with a one-cycle done pulse. The sequencer is idle in the cycle after that.
- R7: If none of the samples shows lock, the sequencer raises a one-cycle error pulse in the cycle after the last sample. No control write with bit 4 set occurs.
- R8: A start request while busy is ignored. The multiplier and control inputs are only sampled when a start is accepted.
- R9: At most one write strobe is high in any cycle, and none is high while the sequencer is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a reprogramming sequence |
| mult_i | input | MULT_W | New multiplier word |
| ctrl_rd_i | input | CTRL_W | Current value of the PLL control register |
| lock_i | input | 1 | PLL lock status bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful lock |
| err_o | output | 1 | One-cycle pulse when lock is not reached |
| ctrl_we_o | output | 1 | Control register write strobe |
| ctrl_wdata_o | output | CTRL_W | Control register write data |
| mult_we_o | output | 1 | Multiplier register write strobe |
| mult_wdata_o | output | MULT_W | Multiplier register write data |
| div_we_o | output | 1 | Divider register write strobe |
| div_wdata_o | output | DIV_W | Divider register write data |

## Verification
Several rules are checked on every cycle:
- Strobe exclusivity, and no strobes while idle.
- The multiplier and divider writes land only while power-down is in force.
- The first write of each run has power-down set and the bypass, direct and enable bits cleared.
- Clock-enable is written only after the lock input was high.
- done and error last one cycle each.

Some behaviour only the bench's scenarios can show:
- The exact cycle of each lock sample, and the fact that a run ends on the fourth try.
- Which control bits are preserved.
- That starts and input changes during a run are ignored.
- Recovery from a reset in the middle of a sequence.

// File: rtl/pll_seq_pkg.sv
// Package: pll_seq_pkg
// Shared bit positions, state type and control-write selector for the
// PLL reprogramming sequencer. Assumes a control register whose low five
// bits carry power-down, bypass, two direct-path bits and clock-enable.
package pll_seq_pkg;

    localparam int PD_BIT   = 0;
    localparam int BYP_BIT  = 1;
    localparam int DIN_BIT  = 2;
    localparam int DOUT_BIT = 3;
    localparam int CEN_BIT  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDN,
        ST_MUL,
        ST_DIV,
        ST_PUP,
        ST_WAIT,
        ST_EN,
        ST_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        CW_NONE,
        CW_DOWN,
        CW_UP,
        CW_ENABLE
    } ctrl_op_e;

endpackage

// File: rtl/pll_seq_timer.sv
// Module: pll_seq_timer
// Counts the lock-poll interval. While run_i is high it counts clock
// cycles and raises tick_o in the last cycle of each WAIT_CYC window,
// then restarts. Assumes WAIT_CYC >= 1; the count clears whenever run_i
// is low, so every window starts from zero.
module pll_seq_timer #(
    parameter int WAIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    // Interval counter: advance while running, restart on tick or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pll_seq_ctrl_fmt.sv
// Module: pll_seq_ctrl_fmt
// Builds the control-register write word from the value captured at start.
// The five managed bits are forced per operation; all other bits pass
// through unchanged. Purely combinational.
module pll_seq_ctrl_fmt
    import pll_seq_pkg::*;
#(
    parameter int CTRL_W = 32
) (
    input  logic [CTRL_W-1:0] base_i,
    input  ctrl_op_e          op_i,
    output logic [CTRL_W-1:0] word_o
);
    localparam logic [CTRL_W-1:0] PD_M  = CTRL_W'(1) << PD_BIT;
    localparam logic [CTRL_W-1:0] CEN_M = CTRL_W'(1) << CEN_BIT;
    localparam logic [CTRL_W-1:0] CLR_M = (CTRL_W'(1) << BYP_BIT)
                                        | (CTRL_W'(1) << DIN_BIT)
                                        | (CTRL_W'(1) << DOUT_BIT)
                                        | CEN_M;

    logic [CTRL_W-1:0] down_w;

    assign down_w = (base_i | PD_M) & ~CLR_M;

    // Select the word for the current control-write step.
    always_comb begin
        unique case (op_i)
            CW_DOWN:   word_o = down_w;
            CW_UP:     word_o = down_w & ~PD_M;
            CW_ENABLE: word_o = (down_w & ~PD_M) | CEN_M;
            default:   word_o = down_w;
        endcase
    end

endmodule

// File: rtl/pll_seq_fsm.sv
// Module: pll_seq_fsm
// Sequencing state machine. Walks power-down, multiplier write, divider
// write, power-up and then up to MAX_TRIES lock polls paced by tick_i.
// Ends in either an enable step or a fail step. Accepts start only in
// idle. Assumes tick_i is high only while run_o is high.
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int MAX_TRIES = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     lock_i,
    input  logic     tick_i,
    output logic     accept_o,
    output logic     run_o,
    output ctrl_op_e ctrl_op_o,
    output logic     mult_we_o,
    output logic     div_we_o,
    output logic     busy_o,
    output logic     done_o,
    output logic     err_o
);
    localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

    seq_state_e       state_q, state_d;
    logic [TRY_W-1:0] tries_q;

    assign accept_o = (state_q == ST_IDLE) && start_i;

    // Next-state selection for the fixed reprogramming order.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_PDN;
            ST_PDN:  state_d = ST_MUL;
            ST_MUL:  state_d = ST_DIV;
            ST_DIV:  state_d = ST_PUP;
            ST_PUP:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (tick_i) begin
                    if (lock_i)                  state_d = ST_EN;
                    else if (tries_q == TRY_LAST) state_d = ST_FAIL;
                end
            end
            ST_EN:   state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Poll counter: cleared at power-up, advanced on each unlocked sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (state_q == ST_PUP) begin
            tries_q <= '0;
        end else if (state_q == ST_WAIT && tick_i && !lock_i) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // Output decode from the current state.
    always_comb begin
        ctrl_op_o = CW_NONE;
        unique case (state_q)
            ST_PDN:  ctrl_op_o = CW_DOWN;
            ST_PUP:  ctrl_op_o = CW_UP;
            ST_EN:   ctrl_op_o = CW_ENABLE;
            default: ctrl_op_o = CW_NONE;
        endcase
    end

    assign run_o     = (state_q == ST_WAIT);
    assign mult_we_o = (state_q == ST_MUL);
    assign div_we_o  = (state_q == ST_DIV);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = (state_q == ST_EN);
    assign err_o     = (state_q == ST_FAIL);

endmodule

// File: rtl/pll_reprog_seq.sv
// Module: pll_reprog_seq
// Top of the PLL reprogramming sequencer. Captures the control value and
// the multiplier word when a start is accepted. Drives the three register
// write ports in a fixed order and reports done or error.
// Assumptions:
//  - ctrl_rd_i reflects the control register when start is raised.
//  - WAIT_CYC is the poll interval expressed in clock cycles.
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int                CTRL_W    = 32,
    parameter int                MULT_W    = 32,
    parameter int                DIV_W     = 32,
    parameter logic [DIV_W-1:0]  DIV_WORD  = 32'h0030_2062,
    parameter int                WAIT_CYC  = 1000,
    parameter int                MAX_TRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [CTRL_W-1:0] ctrl_rd_i,
    input  logic              lock_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              ctrl_we_o,
    output logic [CTRL_W-1:0] ctrl_wdata_o,
    output logic              mult_we_o,
    output logic [MULT_W-1:0] mult_wdata_o,
    output logic              div_we_o,
    output logic [DIV_W-1:0]  div_wdata_o
);
    logic              accept;
    logic              run;
    logic              tick;
    ctrl_op_e          ctrl_op;
    logic [CTRL_W-1:0] base_q;
    logic [MULT_W-1:0] mult_q;

    // Capture control and multiplier inputs on an accepted start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mult_q <= '0;
        end else if (accept) begin
            base_q <= ctrl_rd_i;
            mult_q <= mult_i;
        end
    end

    pll_seq_fsm #(
        .MAX_TRIES (MAX_TRIES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .lock_i    (lock_i),
        .tick_i    (tick),
        .accept_o  (accept),
        .run_o     (run),
        .ctrl_op_o (ctrl_op),
        .mult_we_o (mult_we_o),
        .div_we_o  (div_we_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    pll_seq_timer #(
        .WAIT_CYC (WAIT_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    pll_seq_ctrl_fmt #(
        .CTRL_W (CTRL_W)
    ) u_fmt (
        .base_i (base_q),
        .op_i   (ctrl_op),
        .word_o (ctrl_wdata_o)
    );

    assign ctrl_we_o    = (ctrl_op != CW_NONE);
    assign mult_wdata_o = mult_q;
    assign div_wdata_o  = DIV_WORD;

endmodule

// File: rtl/pll_seq_chk.sv
// Module: pll_seq_chk
// Property checker for pll_reprog_seq, attached with bind. It tracks the
// last power-down value written and relates strobes, data and status
// over time.
module pll_seq_chk
    import pll_seq_pkg::*;
#(
    parameter int CTRL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              ctrl_we_o,
    input logic [CTRL_W-1:0] ctrl_wdata_o,
    input logic              mult_we_o,
    input logic              div_we_o
);
    logic pd_last_q;

    // Remember the power-down bit of the most recent control write.
    always_ff @(posedge clk) begin
        if (!rst_n)         pd_last_q <= 1'b0;
        else if (ctrl_we_o) pd_last_q <= ctrl_wdata_o[PD_BIT];
    end

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_we_o, mult_we_o, div_we_o}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(ctrl_we_o || mult_we_o || div_we_o || done_o || err_o));

    assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ctrl_we_o && ctrl_wdata_o[PD_BIT]
                          && (ctrl_wdata_o[CEN_BIT:BYP_BIT] == 4'b0000));

    assert_cfg_in_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_we_o || div_we_o) |-> pd_last_q);

    assert_enable_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_o && ctrl_wdata_o[CEN_BIT]) |-> $past(lock_i));

    assert_done_with_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ctrl_we_o && ctrl_wdata_o[CEN_BIT] && !ctrl_wdata_o[PD_BIT]);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o && !busy_o);

    assert_end_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

endmodule

bind pll_reprog_seq pll_seq_chk #(
    .CTRL_W (CTRL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_i       (lock_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .ctrl_we_o    (ctrl_we_o),
    .ctrl_wdata_o (ctrl_wdata_o),
    .mult_we_o    (mult_we_o),
    .div_we_o     (div_we_o)
);

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 3;
    localparam int TRIES      = 4;
    localparam logic [31:0] DIVW = 32'h0030_2062;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] mult;
        logic [2:0]  lock_k;   // sample that first sees lock, 0 = never
        logic        ign;      // extra start + input changes while busy
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_0000, 32'h0000_0123, 3'd1, 1'b0},
        '{32'hFFFF_FFFF, 32'h000A_BCDE, 3'd2, 1'b0},
        '{32'h0000_001E, 32'h1234_5678, 3'd4, 1'b0},
        '{32'h5A5A_5A40, 32'h0000_0F0F, 3'd0, 1'b0},
        '{32'h0000_0010, 32'hCAFE_0001, 3'd3, 1'b1},
        '{32'h8000_0003, 32'h0000_0042, 3'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] mult_i = '0;
    logic [31:0] ctrl_rd_i = '0;
    logic        lock_i = 1'b0;
    logic        busy_o, done_o, err_o;
    logic        ctrl_we_o, mult_we_o, div_we_o;
    logic [31:0] ctrl_wdata_o, mult_wdata_o, div_wdata_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_reprog_seq #(
        .WAIT_CYC  (W),
        .MAX_TRIES (TRIES)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mult_i       (mult_i),
        .ctrl_rd_i    (ctrl_rd_i),
        .lock_i       (lock_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .ctrl_we_o    (ctrl_we_o),
        .ctrl_wdata_o (ctrl_wdata_o),
        .mult_we_o    (mult_we_o),
        .mult_wdata_o (mult_wdata_o),
        .div_we_o     (div_we_o),
        .div_wdata_o  (div_wdata_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {busy_o, done_o, err_o, ctrl_we_o, mult_we_o, div_we_o};
    endfunction

    // One full sequence from a vector; compares every cycle.
    task automatic run_vec(input vec_t v);
        logic [31:0] exp_pd, exp_pu, exp_en;
        logic [5:0]  exp_o, bad_a, bad_e;
        bit          ok_lock, seq_ok;
        int          end_c;
        exp_pd  = (v.ctrl | 32'h1) & ~32'h1E;
        exp_pu  = exp_pd & ~32'h1;
        exp_en  = exp_pu | 32'h10;
        ok_lock = (v.lock_k != 0);
        end_c   = ok_lock ? 4 + int'(v.lock_k) * W + 1 : 4 + TRIES * W + 1;
        seq_ok  = 1'b1;
        bad_a   = '0;
        bad_e   = '0;
        @(negedge clk);
        start_i   = 1'b1;
        mult_i    = v.mult;
        ctrl_rd_i = v.ctrl;
        for (int c = 1; c <= end_c + 2; c++) begin
            @(negedge clk);
            exp_o = {(c >= 1 && c <= end_c), (ok_lock && c == end_c),
                     (!ok_lock && c == end_c),
                     (c == 1 || c == 4 || (ok_lock && c == end_c)),
                     (c == 2), (c == 3)};
            if (outs() !== exp_o && seq_ok) begin
                seq_ok = 1'b0;
                bad_a  = outs();
                bad_e  = exp_o;
            end
            if (c == 1) chk(ctrl_wdata_o === exp_pd, "R2", "power-down word", ctrl_wdata_o, exp_pd);
            if (c == 2) chk(mult_wdata_o === v.mult, "R3/R8", "multiplier word", mult_wdata_o, v.mult);
            if (c == 3) chk(div_wdata_o === DIVW, "R3", "divider word", div_wdata_o, DIVW);
            if (c == 4) chk(ctrl_wdata_o === exp_pu, "R4", "power-up word", ctrl_wdata_o, exp_pu);
            if (ok_lock && c == end_c)
                chk(ctrl_wdata_o === exp_en, "R6", "enable word", ctrl_wdata_o, exp_en);
            // drive for this cycle
            start_i   = v.ign && (c == 2 || c == 3 || c == 6);
            mult_i    = v.ign ? ~v.mult : v.mult;
            ctrl_rd_i = v.ign ? ~v.ctrl : v.ctrl;
            lock_i    = ok_lock && (c >= 5 + (int'(v.lock_k) - 1) * W);
        end
        // R5 R7 R9 R8: full per-cycle strobe/status pattern
        chk(seq_ok, ok_lock ? "R5/R6/R9" : "R5/R7/R9",
            v.ign ? "sequence pattern (busy start R8)" : "sequence pattern",
            32'(bad_a), 32'(bad_e));
        start_i = 1'b0;
        lock_i  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(outs() === 6'b0, "R1", "reset outputs", 32'(outs()), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() === 6'b0, "R1", "idle after reset", 32'(outs()), 32'h0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R1: reset in the middle of a sequence
        @(negedge clk);
        start_i = 1'b1;
        mult_i  = 32'h77;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy_o === 1'b1, "R1", "busy before mid reset", 32'(busy_o), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(outs() === 6'b0, "R1", "mid-sequence reset", 32'(outs()), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(outs() === 6'b0, "R1", "stays idle after reset", 32'(outs()), 32'h0);

        // recovery run after reset
        run_vec('{32'h0000_0F00, 32'h0000_0099, 3'd1, 1'b0});

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule